// File: doc/BRIEF.md
# Character LCD Power-Up Sequencer

This block takes a character LCD from an unknown state after reset to 4-bit, two-line operation. It then serves a small host port. It does not drive the display pins itself. Each step goes to a nibble bus engine as one of two requests: a raw single-nibble strobe, used before 4-bit mode is known to be set, or a full byte command, which the engine splits into two nibbles and guards with busy polling. The engine reports each finished transfer with a one-cycle `eng_done` pulse. A millisecond timebase built from a clock-cycle prescaler sets the fixed waits, and every wait length is a parameter.

The interface can be in 8-bit mode, or halfway through a 4-bit pair, when reset is released. For this reason the sequencer first strobes the nibble 0x3 three times with timed waits, which puts nibble alignment in a known state. It then strobes 0x2 once to select 4-bit transfers. After that it sends its configuration bytes, then clear and return-home, and raises `host_ready`.

The state register moves through these states. POWERUP holds the power-on wait; when the delay expires it goes to NIB_GO. NIB_GO issues one raw nibble and goes to NIB_WAIT. NIB_WAIT goes to NIB_DLY on `eng_done`. NIB_DLY loops back to NIB_GO for the next nibble, or goes to CMD_GO after the fourth. CMD_GO issues one byte and goes to CMD_WAIT. CMD_WAIT goes back to CMD_GO for the next list byte, or to READY after the last byte of the current list. READY goes to CMD_GO when the host makes a request.

Top module: `lcd_init_seq`

## Requirements
- R1: During reset and right after it, `host_ready` is 0, `busy` is 1, `eng_rs` is 0, and no strobe request is issued.
- R2: The first raw nibble is not issued before PWR_MS milliseconds (PWR_MS × CLK_HZ/1000 cycles) have passed since reset was released.
- R3: The first four requests are raw nibbles with register select 0, in this order: 0x3, 0x3, 0x3, 0x2 (`eng_nib_go` with `eng_nib`).
- R4: After each raw nibble's `eng_done`, the next request waits its own delay. These are NIB1_MS, NIB2_MS and NIB3_MS after the three 0x3 nibbles, and MODE_MS after 0x2. No busy polling is involved.
- R5: Next come byte commands with `eng_rs`=0, in this order: 0x28, 0x14, 0x06, 0x0C, 0x01, 0x02. A new request is issued only after `eng_done` for the previous one, and at most one request is outstanding.
- R6: `host_ready` rises only after `eng_done` for the final 0x02. `busy` is always the inverse of `host_ready`, and no request is issued while ready.
- R7: A request with `host_op`=2 (set position) issues byte 0x80 OR `host_data` with `eng_rs`=0. Address 0x00 is the start of line one and 0x40 the start of line two.
- R8: A request with `host_op`=0 (character) passes `host_data` through unchanged as one byte with `eng_rs`=1.
- R9: A request with `host_op`=1 (clear and home) issues 0x01 and then 0x02. `host_ready` is 0 from the cycle after acceptance until that 0x02 completes.
- R10: A `host_valid` raised while `host_ready` is 0 is ignored: it produces no request, either at that time or later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host request; accepted in a cycle where host_ready is 1 |
| host_op | input | 2 | 0 character, 1 clear and home, 2 set position |
| host_data | input | 8 | Character code or cursor address |
| host_ready | output | 1 | Sequencer idle and able to accept a request |
| busy | output | 1 | Initialization or a host request in progress |
| eng_done | input | 1 | Engine finished the current request (one-cycle pulse) |
| eng_nib_go | output | 1 | One-cycle raw nibble strobe request |
| eng_nib | output | 4 | Nibble value for eng_nib_go |
| eng_byte_go | output | 1 | One-cycle busy-polled byte request |
| eng_byte | output | 8 | Byte value for eng_byte_go |
| eng_rs | output | 1 | Register select: 0 command, 1 character data |

## Verification
A wrong list index or a skipped state shows up as a wrong or missing value in the ordered request log. That log is checked entry by entry, so the first divergent request pins the fault to a specific step. A delay loaded with the wrong length, or a delay that is never started, shows up in the spacing between consecutive strobes within a few milliseconds of reset. A `host_ready` that is released early, or a request leaking in before ready, appears as an extra logged request or a high ready during a clear sequence.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    typedef enum logic [2:0] {
        ST_POWERUP,
        ST_NIB_GO,
        ST_NIB_WAIT,
        ST_NIB_DLY,
        ST_CMD_GO,
        ST_CMD_WAIT,
        ST_READY
    } seq_state_t;

    localparam logic [1:0] OP_CHAR  = 2'd0;
    localparam logic [1:0] OP_CLEAR = 2'd1;
    localparam logic [1:0] OP_GOTO  = 2'd2;

    // command list slots: 0..3 configuration, 4..5 clear/home,
    // 6 host position, 7 host character
    localparam logic [2:0] SLOT_CLEAR = 3'd4;
    localparam logic [2:0] SLOT_HOME  = 3'd5;
    localparam logic [2:0] SLOT_GOTO  = 3'd6;
    localparam logic [2:0] SLOT_CHAR  = 3'd7;

    function automatic logic [7:0] slot_byte(input logic [2:0] slot,
                                             input logic [7:0] hold);
        logic [7:0] b;
        unique case (slot)
            3'd0:    b = 8'h28;
            3'd1:    b = 8'h14;
            3'd2:    b = 8'h06;
            3'd3:    b = 8'h0C;
            3'd4:    b = 8'h01;
            3'd5:    b = 8'h02;
            3'd6:    b = 8'h80 | hold;
            default: b = hold;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/lcd_ms_tick.sv
module lcd_ms_tick #(
    parameter int CYC_PER_MS = 16000
) (
    input  logic clk,
    input  logic restart,
    output logic tick
);
    localparam int CNT_W = $clog2(CYC_PER_MS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC_PER_MS - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (restart || cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = (cnt == LAST) && !restart;
endmodule

// File: rtl/lcd_ms_delay.sv
module lcd_ms_delay #(
    parameter int MS_W   = 8,
    parameter int RST_MS = 15
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [MS_W-1:0] ms,
    input  logic            tick,
    output logic            done
);
    logic [MS_W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= MS_W'(RST_MS);
        end else if (start) begin
            left <= ms;
        end else if (tick && left != '0) begin
            left <= left - 1'b1;
        end
    end

    assign done = (left == '0) && !start;
endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
    import lcd_seq_pkg::*;
#(
    parameter int CLK_HZ  = 16_000_000,
    parameter int MS_W    = 8,
    parameter int PWR_MS  = 15,
    parameter int NIB1_MS = 15,
    parameter int NIB2_MS = 5,
    parameter int NIB3_MS = 5,
    parameter int MODE_MS = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_valid,
    input  logic [1:0] host_op,
    input  logic [7:0] host_data,
    output logic       host_ready,
    output logic       busy,
    input  logic       eng_done,
    output logic       eng_nib_go,
    output logic [3:0] eng_nib,
    output logic       eng_byte_go,
    output logic [7:0] eng_byte,
    output logic       eng_rs
);
    localparam int MS_CYC  = CLK_HZ / 1000;
    localparam int PWR_CYC = PWR_MS * MS_CYC;

    seq_state_t      state;
    logic [1:0]      nib_idx;
    logic [2:0]      slot;
    logic [7:0]      hold;
    logic            tick;
    logic            dly_start;
    logic            dly_done;
    logic [MS_W-1:0] dly_ms;
    logic            slot_last;

    lcd_ms_tick #(.CYC_PER_MS(MS_CYC)) u_tick (
        .clk     (clk),
        .restart (rst | dly_start),
        .tick    (tick)
    );

    lcd_ms_delay #(.MS_W(MS_W), .RST_MS(PWR_MS)) u_delay (
        .clk   (clk),
        .rst   (rst),
        .start (dly_start),
        .ms    (dly_ms),
        .tick  (tick),
        .done  (dly_done)
    );

    assign dly_start = (state == ST_NIB_WAIT) && eng_done;
    assign slot_last = (slot == SLOT_HOME) || (slot == SLOT_GOTO) || (slot == SLOT_CHAR);

    always_comb begin
        unique case (nib_idx)
            2'd0:    dly_ms = MS_W'(NIB1_MS);
            2'd1:    dly_ms = MS_W'(NIB2_MS);
            2'd2:    dly_ms = MS_W'(NIB3_MS);
            default: dly_ms = MS_W'(MODE_MS);
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_POWERUP;
            nib_idx <= '0;
            slot    <= '0;
            hold    <= '0;
        end else begin
            unique case (state)
                ST_POWERUP: begin
                    if (dly_done) begin
                        state   <= ST_NIB_GO;
                        nib_idx <= '0;
                    end
                end
                ST_NIB_GO:   state <= ST_NIB_WAIT;
                ST_NIB_WAIT: if (eng_done) state <= ST_NIB_DLY;
                ST_NIB_DLY: begin
                    if (dly_done) begin
                        if (nib_idx == 2'd3) begin
                            state <= ST_CMD_GO;
                            slot  <= '0;
                        end else begin
                            nib_idx <= nib_idx + 1'b1;
                            state   <= ST_NIB_GO;
                        end
                    end
                end
                ST_CMD_GO:   state <= ST_CMD_WAIT;
                ST_CMD_WAIT: begin
                    if (eng_done) begin
                        if (slot_last) begin
                            state <= ST_READY;
                        end else begin
                            slot  <= slot + 1'b1;
                            state <= ST_CMD_GO;
                        end
                    end
                end
                ST_READY: begin
                    if (host_valid) begin
                        hold  <= host_data;
                        state <= ST_CMD_GO;
                        if (host_op == OP_CLEAR)     slot <= SLOT_CLEAR;
                        else if (host_op == OP_GOTO) slot <= SLOT_GOTO;
                        else                         slot <= SLOT_CHAR;
                    end
                end
                default: state <= ST_POWERUP;
            endcase
        end
    end

    // outputs
    always_comb begin
        host_ready  = (state == ST_READY);
        busy        = (state != ST_READY);
        eng_nib_go  = (state == ST_NIB_GO);
        eng_nib     = (nib_idx == 2'd3) ? 4'h2 : 4'h3;
        eng_byte_go = (state == ST_CMD_GO);
        eng_byte    = slot_byte(slot, hold);
        eng_rs      = (slot == SLOT_CHAR) &&
                      ((state == ST_CMD_GO) || (state == ST_CMD_WAIT));
    end

endmodule

// File: rtl/lcd_init_seq_chk.sv
module lcd_init_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        host_valid,
    input logic        host_ready,
    input logic        eng_done,
    input logic        eng_nib_go,
    input logic [3:0]  eng_nib,
    input logic        eng_byte_go,
    input logic        eng_rs,
    input logic [31:0] pwr_cycles
);
    logic [31:0] since_rst;
    logic        seen_go;
    logic        pending;
    logic [2:0]  nib_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
            seen_go   <= 1'b0;
            pending   <= 1'b0;
            nib_cnt   <= '0;
        end else begin
            if (since_rst != 32'hFFFF_FFFF) since_rst <= since_rst + 1;
            if (eng_nib_go || eng_byte_go) seen_go <= 1'b1;
            if (eng_nib_go || eng_byte_go) pending <= 1'b1;
            else if (eng_done)             pending <= 1'b0;
            if (eng_nib_go && nib_cnt != 3'd7) nib_cnt <= nib_cnt + 1'b1;
        end
    end

    always_comb begin
        if (rst) begin
            p_reset_quiet_r1: assert (!eng_nib_go && !eng_byte_go && !eng_rs);
        end
    end

    p_pwr_wait_r2: assert property (@(posedge clk) disable iff (rst)
        (eng_nib_go && !seen_go) |-> (since_rst >= pwr_cycles));

    p_nib_order_r3: assert property (@(posedge clk) disable iff (rst)
        eng_nib_go |-> (nib_cnt < 3'd4) && (eng_nib == ((nib_cnt == 3'd3) ? 4'h2 : 4'h3)));

    p_one_pending_r5: assert property (@(posedge clk) disable iff (rst)
        (eng_nib_go || eng_byte_go) |-> !pending && !(eng_nib_go && eng_byte_go));

    p_quiet_ready_r6: assert property (@(posedge clk) disable iff (rst)
        host_ready |-> !eng_nib_go && !eng_byte_go);

    p_ready_drop_r9: assert property (@(posedge clk) disable iff (rst)
        (host_valid && host_ready) |=> !host_ready && eng_byte_go);

endmodule

bind lcd_init_seq lcd_init_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_valid  (host_valid),
    .host_ready  (host_ready),
    .eng_done    (eng_done),
    .eng_nib_go  (eng_nib_go),
    .eng_nib     (eng_nib),
    .eng_byte_go (eng_byte_go),
    .eng_rs      (eng_rs),
    .pwr_cycles  (32'(PWR_CYC))
);

// File: tb/lcd_init_seq_bench.sv
module lcd_init_seq_bench;
    localparam int CLK_HZ = 8000;
    localparam int MS     = CLK_HZ / 1000;
    localparam int LAT    = 3;
    localparam int NV     = 14;
    // entry: [9]=raw nibble, [8]=rs, [7:0]=value
    localparam logic [9:0] EXP [NV] = '{
        10'h203, 10'h203, 10'h203, 10'h202,
        10'h028, 10'h014, 10'h006, 10'h00C, 10'h001, 10'h002,
        10'h0C5, 10'h141, 10'h001, 10'h002
    };
    localparam int GAP [4] = '{15, 5, 5, 5};

    logic       clk = 0;
    logic       rst = 1;
    logic       host_valid = 0;
    logic [1:0] host_op = 0;
    logic [7:0] host_data = 0;
    logic       host_ready, busy, eng_done, eng_nib_go, eng_byte_go, eng_rs;
    logic [3:0] eng_nib;
    logic [7:0] eng_byte;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int n_log  = 0;
    int pend   = 0;
    logic [9:0] log_op  [32];
    int         log_cyc [32];

    always #5 clk = ~clk;

    lcd_init_seq #(.CLK_HZ(CLK_HZ)) u_lcd_init_seq (
        .clk(clk), .rst(rst), .host_valid(host_valid), .host_op(host_op),
        .host_data(host_data), .host_ready(host_ready), .busy(busy),
        .eng_done(eng_done), .eng_nib_go(eng_nib_go), .eng_nib(eng_nib),
        .eng_byte_go(eng_byte_go), .eng_byte(eng_byte), .eng_rs(eng_rs)
    );

    assign eng_done = (pend == 1);

    always @(posedge clk) begin
        if (rst) begin
            cyc  <= 0;
            pend <= 0;
        end else begin
            cyc <= cyc + 1;
            if (eng_nib_go || eng_byte_go) begin
                pend <= LAT;
                if (n_log < 32) begin
                    log_op[n_log]  <= eng_nib_go ? {2'b10, 4'h0, eng_nib} : {1'b0, eng_rs, eng_byte};
                    log_cyc[n_log] <= cyc;
                end
                n_log <= n_log + 1;
            end else if (pend > 0) begin
                pend <= pend - 1;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] op, input logic [7:0] d, input string req);
        wait (host_ready);
        @(negedge clk);
        host_valid = 1; host_op = op; host_data = d;
        @(negedge clk);
        host_valid = 0;
        check(req, int'(host_ready), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 ready", int'(host_ready), 0);
        check("R1 busy", int'(busy), 1);
        check("R1 rs", int'(eng_rs), 0);
        rst = 0;
        @(negedge clk);
        check("R1 no strobe", int'(eng_nib_go | eng_byte_go), 0);
        // R10: request while not ready must be ignored
        repeat (30) @(negedge clk);
        host_valid = 1; host_op = 2'd0; host_data = 8'h55;
        repeat (5) @(negedge clk);
        host_valid = 0;
        wait (host_ready);
        @(negedge clk);
        check("R6 ready after init", int'(host_ready), 1);
        check("R6 busy inverse", int'(busy), 0);
        check("R6 init count", n_log, 10);
        send(2'd2, 8'h45, "R7 goto drops ready");
        send(2'd0, 8'h41, "R8 char drops ready");
        send(2'd1, 8'h00, "R9 clear drops ready");
        wait (n_log == 13);
        @(negedge clk);
        check("R9 ready low between pair", int'(host_ready), 0);
        wait (host_ready);
        repeat (10) @(negedge clk);
        check("R10 exact request count", n_log, NV);
        for (int i = 0; i < NV; i++) begin
            check($sformatf("R3/R5/R7/R8/R9 entry %0d", i), int'(log_op[i]), int'(EXP[i]));
        end
        check("R2 power-up wait", int'(log_cyc[0] >= 15 * MS), 1);
        for (int k = 0; k < 4; k++) begin
            check($sformatf("R4 gap %0d", k),
                  int'(log_cyc[k+1] - log_cyc[k] >= GAP[k] * MS + LAT), 1);
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule